// File: doc/BRIEF.md
# Pipelined Burst SRAM Core with Dual Address Strobes

This block is a single-clock synchronous static RAM with 32-bit words and a 15-bit word address. An access opens when one of two active-low address strobes is accepted and the three chip selects all agree. One strobe is meant for a processor and the other for a memory controller. The address is held in a register. Its two lowest bits start a 2-bit burst counter, which steps on an active-low advance input. A static order input picks linear or interleaved stepping. Writes are either all-lane or per-lane, using four active-low lane selects. Read data is registered. The bidirectional data pads are split into a write-data input, a read-data output and a drive-enable output. The output enable combines with that drive enable without passing through a register.

Control is a two-state machine. `ST_DESEL` means no access is open. `ST_ACTIVE` means the address register names a location, and the edge that closes each cycle either reads or writes it. There are three transitions. Open: an accepted strobe with the chip selected, from either state, goes to `ST_ACTIVE`. Close: an accepted strobe with the chip not selected, from either state, goes to `ST_DESEL`. Stay: no accepted strobe keeps the state.

The storage covers `2**MEM_AW` words. Address bits above `MEM_AW` are carried through the burst logic but do not select storage.

Top module: `bsram_core`

## Requirements
- R1: In `ST_DESEL` no access is made. `rdata` keeps its value and `rdata_oe` stays low, even if write enables are asserted. A strobe accepted while any of the three selects is inactive (`sel1_n` high, `sel2` low or `sel3_n` high) enters `ST_DESEL`.
- R2: At an edge where a strobe is accepted with the chip selected, the whole address is stored and the burst step count is cleared. The stored upper bits (above bit 1) do not change until the next accepted strobe, including when the burst wraps.
- R3: If both strobes are low and `sel1_n` is low, the processor strobe wins. The first access after a processor-strobe open is always a read, and write enables at that edge are ignored. An open by the controller strobe may write on its first access.
- R4: The processor strobe has no effect while `sel1_n` is high. With the controller strobe high, the cycle behaves as if no strobe were present, so the advance input still acts.
- R5: In `ST_ACTIVE`, with no accepted strobe, `step_n` low advances the step count by one (mod 4) after the access at that edge. `step_n` high holds the address.
- R6: With `order_ilv` = 0 (linear), the low two address bits are (start + step) mod 4.
- R7: With `order_ilv` = 1 (interleaved), the low two address bits are start XOR step.
- R8: `wr_all_n` low at an access edge writes all four bytes of `wdata`, whatever `wr_byte_n` and `lane_n` are.
- R9: With `wr_all_n` high and `wr_byte_n` low, only the byte lanes whose `lane_n` bit is low are written. Lane b is `wdata[8b+7:8b]`. With both write enables high, the access is a read.
- R10: A read access at an edge loads `rdata` with the addressed word at that same edge. After a strobe opens an address, the word is on `rdata` one clock later.
- R11: `rdata_oe` follows `rd_en_n` without a clock: it is low whenever `rd_en_n` is high. After a write access, `rdata_oe` is low until the next read access edge.
- R12: In the cycle after an open from `ST_DESEL`, `rdata_oe` is held low. An open from `ST_ACTIVE` leaves it driving.
- R13: Addresses that are equal in bits `[MEM_AW-1:0]` (bits [9:0] by default) select the same word.
- R14: After reset the state is `ST_DESEL`, `rdata` is zero and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (15) | Word address, stored when a strobe is accepted |
| strb_cpu_n | input | 1 | Processor address strobe, active low, has priority |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| step_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | All-lane write enable, active low |
| wr_byte_n | input | 1 | Per-lane write enable, active low |
| lane_n | input | LANES (4) | Lane selects, active low, bit b for byte b |
| rd_en_n | input | 1 | Output enable, active low, unclocked |
| wdata | input | DATA_W (32) | Write data, sampled with the write enables |
| rdata | output | DATA_W (32) | Registered read data |
| rdata_oe | output | 1 | Pad drive enable for rdata |

## Verification
The clocked properties assume that `order_ilv` does not change inside a burst. They also assume that the address and strobes are settled at each rising edge. The bench changes the order input only between bursts, while no advance is being applied. It drives every input one nanosecond after an edge and reads results there as well. Because the storage is not reset, the bench reads back only words it has written earlier. It keeps its test addresses distinct in the low ten bits, except where aliasing is the point of the check.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic {
        ST_DESEL  = 1'b0,
        ST_ACTIVE = 1'b1
    } bs_state_e;

    localparam int LANE_W = 8;
endpackage

// File: rtl/bsram_strobe_arb.sv
module bsram_strobe_arb (
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    output logic take_cpu,
    output logic open_go,
    output logic close_go
);
    logic take_ctl;
    logic chip_on;
    logic any_take;

    always_comb begin
        // processor strobe counts only while select 1 is active; it then wins
        take_cpu = !strb_cpu_n && !sel1_n;
        take_ctl = !strb_ctl_n && !take_cpu;
        any_take = take_cpu || take_ctl;
        chip_on  = !sel1_n && sel2 && !sel3_n;
        open_go  = any_take && chip_on;
        close_go = any_take && !chip_on;
    end
endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_go,
    input  logic          adv_go,
    input  logic          order_ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_cur
);
    logic [AW-1:2] hi_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;
    logic [1:0]    low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (open_go) begin
            hi_q    <= addr_in[AW-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
        end else if (adv_go) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        if (order_ilv) low_bits = start_q ^ cnt_q;
        else           low_bits = start_q + cnt_q;
        addr_cur = {hi_q, low_bits};
    end

    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        open_go |=> (cnt_q == 2'd0) && (start_q == $past(addr_in[1:0])));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_go && !open_go) |=> (cnt_q == $past(cnt_q) + 2'd1));

    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_go && !open_go) |=> $stable(cnt_q) && $stable(start_q));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int MEM_AW = 10,
    parameter int LANES  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [MEM_AW-1:0]                   idx,
    input  logic [LANES-1:0]                    wr_lane,
    input  logic                                rd_go,
    input  logic [LANES*bsram_pkg::LANE_W-1:0]  wdata,
    output logic [LANES*bsram_pkg::LANE_W-1:0]  rdata
);
    localparam int LW    = bsram_pkg::LANE_W;
    localparam int DEPTH = 1 << MEM_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem_l [DEPTH];
        logic [LW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_lane[g]) mem_l[idx] <= wdata[g*LW +: LW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_go) rd_q <= mem_l[idx];
        end

        assign rdata[g*LW +: LW] = rd_q;
    end
endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 10,
    parameter int LANES  = 4,
    parameter int DATA_W = LANES * bsram_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              step_n,
    input  logic              order_ilv,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    import bsram_pkg::*;

    bs_state_e         st_q, st_nx;
    logic              take_cpu, open_go, close_go;
    logic              adv_go, wr_go, rd_go;
    logic              first_rd_q, drive_q;
    logic [LANES-1:0]  wr_lane;
    logic [ADDR_W-1:0] addr_cur;

    bsram_strobe_arb u_arb (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .take_cpu   (take_cpu),
        .open_go    (open_go),
        .close_go   (close_go)
    );

    bsram_burst_addr #(.AW(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_go   (open_go),
        .adv_go    (adv_go),
        .order_ilv (order_ilv),
        .addr_in   (addr),
        .addr_cur  (addr_cur)
    );

    bsram_array #(.MEM_AW(MEM_AW), .LANES(LANES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (addr_cur[MEM_AW-1:0]),
        .wr_lane (wr_lane),
        .rd_go   (rd_go),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    // access decode for the edge that closes the current cycle
    always_comb begin
        wr_go   = (st_q == ST_ACTIVE) && !first_rd_q && (!wr_all_n || !wr_byte_n);
        rd_go   = (st_q == ST_ACTIVE) && !wr_go;
        wr_lane = '0;
        if (wr_go) wr_lane = !wr_all_n ? {LANES{1'b1}} : ~lane_n;
        adv_go  = (st_q == ST_ACTIVE) && !step_n && !open_go && !close_go;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_DESEL:  if (open_go)  st_nx = ST_ACTIVE;
            ST_ACTIVE: if (close_go) st_nx = ST_DESEL;
            default:   st_nx = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DESEL;
        else        st_q <= st_nx;
    end

    // registered outputs of the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_rd_q <= 1'b0;
            drive_q    <= 1'b0;
        end else begin
            first_rd_q <= open_go && take_cpu;
            drive_q    <= (st_q == ST_ACTIVE) && (st_nx == ST_ACTIVE) && !wr_go;
        end
    end

    assign rdata_oe = drive_q && !rd_en_n;

    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DESEL) |=> $stable(rdata) && !drive_q);

    p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ACTIVE) && !open_go) |=> $stable(addr_cur[ADDR_W-1:2]));

    p_cpu_first_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_go && take_cpu) |=> (wr_lane == '0));

    p_write_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lane != '0) |=> !rdata_oe);

    p_first_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DESEL) && open_go) |=> !rdata_oe);
endmodule

// File: tb/sim_bsram_core.sv
module sim_bsram_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] addr;
    logic        strb_cpu_n, strb_ctl_n, sel1_n, sel2, sel3_n;
    logic        step_n, order_ilv, wr_all_n, wr_byte_n, rd_en_n;
    logic [3:0]  lane_n;
    logic [31:0] wdata, rdata;
    logic        rdata_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bsram_core u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .step_n(step_n), .order_ilv(order_ilv),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .rd_en_n(rd_en_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet_in();
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = 4'hF;
    endtask

    task automatic open_ctl(input logic [14:0] a);
        quiet_in();
        addr = a; strb_ctl_n = 1'b0;
        tick();
        strb_ctl_n = 1'b1;
    endtask

    task automatic read_one(input logic [14:0] a, output logic [31:0] d);
        open_ctl(a);
        tick();
        d = rdata;
    endtask

    // global writes with lane selects set against them (R8)
    task automatic write_burst(input logic [14:0] a, input logic [31:0] d [4]);
        open_ctl(a);
        for (int i = 0; i < 4; i++) begin
            wr_all_n = 1'b0; wr_byte_n = 1'b0; lane_n = 4'b0111;
            wdata = d[i]; step_n = 1'b0;
            tick();
        end
        quiet_in();
    endtask

    logic [31:0] lin_d [4] = '{32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003};
    logic [31:0] ilv_d [4] = '{32'h5555_0010, 32'h6666_0011, 32'h7777_0012, 32'h8888_0013};

    task automatic t_reset();
        chk("R14 rdata after reset", rdata, 32'h0);
        chk("R14 rdata_oe after reset", {31'b0, rdata_oe}, 32'h0);
    endtask

    task automatic t_linear();
        logic [31:0] d;
        order_ilv = 1'b0;
        write_burst(15'h0102, lin_d);
        read_one(15'h0102, d); chk("R6 R8 linear step0", d, lin_d[0]);
        read_one(15'h0103, d); chk("R6 linear step1", d, lin_d[1]);
        read_one(15'h0100, d); chk("R6 R2 linear wrap step2", d, lin_d[2]);
        read_one(15'h0101, d); chk("R6 linear step3", d, lin_d[3]);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        read_one(15'h0500, d); chk("R13 alias of 0x100", d, lin_d[2]);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        read_one(15'h0101, d); chk("R10 read one clock after open", d, lin_d[3]);
        tick(); chk("R5 hold address", rdata, lin_d[3]);
    endtask

    task automatic t_ignore_cpu();
        // open at 0x101 (start 1); a gated processor strobe must not reload
        quiet_in();
        addr = 15'h0100; strb_cpu_n = 1'b0; sel1_n = 1'b1; step_n = 1'b0;
        tick();
        quiet_in(); sel1_n = 1'b0;
        tick();
        chk("R4 gated cpu strobe, advance to 0x102", rdata, lin_d[0]);
    endtask

    task automatic t_interleaved();
        logic [31:0] d;
        order_ilv = 1'b1;
        write_burst(15'h0201, ilv_d);
        read_one(15'h0200, d); chk("R7 ilv 1^1", d, ilv_d[1]);
        read_one(15'h0203, d); chk("R7 ilv 1^2", d, ilv_d[2]);
        open_ctl(15'h0202);
        step_n = 1'b0;
        tick(); chk("R7 R10 ilv burst 0", rdata, ilv_d[3]);
        chk("R11 driving during read burst", {31'b0, rdata_oe}, 32'h1);
        tick(); chk("R7 ilv burst 1", rdata, ilv_d[2]);
        tick(); chk("R7 ilv burst 2", rdata, ilv_d[1]);
        tick(); chk("R7 ilv burst 3", rdata, ilv_d[0]);
        quiet_in();
        order_ilv = 1'b0;
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        open_ctl(15'h0300);
        wr_all_n = 1'b0; wdata = 32'hAAAA_AAAA;
        tick();
        chk("R11 no drive after write", {31'b0, rdata_oe}, 32'h0);
        open_ctl(15'h0300);
        wr_byte_n = 1'b0; lane_n = 4'b1010; wdata = 32'h1122_3344;
        tick();
        quiet_in();
        read_one(15'h0300, d); chk("R9 lanes 0 and 2 written", d, 32'hAA22_AA44);
        open_ctl(15'h0300);
        lane_n = 4'b0000; wdata = 32'h0;
        tick();
        quiet_in();
        read_one(15'h0300, d); chk("R9 lanes without enable ignored", d, 32'hAA22_AA44);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        quiet_in();
        addr = 15'h0300; strb_cpu_n = 1'b0; strb_ctl_n = 1'b0;
        tick();
        quiet_in();
        wr_all_n = 1'b0; wdata = 32'hDEAD_BEEF;
        tick();
        quiet_in();
        chk("R3 cpu-opened first access reads", rdata, 32'hAA22_AA44);
        read_one(15'h0300, d); chk("R3 write ignored", d, 32'hAA22_AA44);
    endtask

    task automatic t_deselect();
        logic [31:0] d;
        read_one(15'h0100, d); chk("R10 read 0x100", d, lin_d[2]);
        quiet_in();
        sel2 = 1'b0; strb_ctl_n = 1'b0;
        tick();
        quiet_in(); sel2 = 1'b1;
        chk("R1 no drive when deselected", {31'b0, rdata_oe}, 32'h0);
        wr_all_n = 1'b0; wdata = 32'h5555_5555; step_n = 1'b0;
        tick(); tick();
        chk("R1 rdata stable while deselected", rdata, lin_d[2]);
        chk("R1 still no drive", {31'b0, rdata_oe}, 32'h0);
        open_ctl(15'h0101);
        chk("R12 first clock masked", {31'b0, rdata_oe}, 32'h0);
        tick();
        chk("R12 drive after masked clock", {31'b0, rdata_oe}, 32'h1);
        chk("R10 data after reopen", rdata, lin_d[3]);
        read_one(15'h0100, d); chk("R1 no write while deselected", d, lin_d[2]);
        open_ctl(15'h0102);
        chk("R12 open from active keeps drive", {31'b0, rdata_oe}, 32'h1);
    endtask

    task automatic t_async_oe();
        rd_en_n = 1'b1; #1;
        chk("R11 oe high kills drive", {31'b0, rdata_oe}, 32'h0);
        rd_en_n = 1'b0; #1;
        chk("R11 oe low restores drive", {31'b0, rdata_oe}, 32'h1);
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        quiet_in();
        addr = '0; wdata = '0; order_ilv = 1'b0; rd_en_n = 1'b0;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_linear();
        t_alias();
        t_hold();
        t_ignore_cpu();
        t_interleaved();
        t_bytes();
        t_priority();
        t_deselect();
        t_async_oe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule